// File: doc/BRIEF.md
# Lane Margining Command Responder

This block is the receiver-side command logic for one lane of a serial link that supports margining. Software writes a 16-bit command word into the lane's control register. The block decodes the word and keeps a 16-bit status word that software reads back. Three kinds of command are handled:

- Report requests return a capability or limit taken from strap inputs.
- Set requests change the error limit, clear the error count or return the lane to normal settings, and are acknowledged by echoing the written word.
- Step requests start a timing or voltage margin excursion.

The analog excursion itself is not modelled, apart from a settle delay counted in clock cycles. While a step is active, the status word carries a 2-bit margin status and a 6-bit error count. The error count is fed by an error-injection input.

A command word is laid out as follows:

| Bits | Field |
|---|---|
| 2:0 | Receiver number |
| 5:3 | Command type |
| 7:6 | Written as zero by this block in every word it forms |
| 15:8 | Payload |

The command types are:

| Type | Meaning |
|---|---|
| 1 | Report |
| 2 | Set |
| 3 | Timing step |
| 4 | Voltage step |
| 7 | Idle (no command) |

Commands addressed to another receiver number are ignored. The idle word is the one exception and is accepted from any receiver number.

Top module: `lane_margin_responder`

## Requirements
- R1: While reset is asserted and right after it, the status word is the idle word 0x9C38 (payload 0x9C, type 7, receiver 0), and the error limit is DEF_LIMIT (default 4).
- R2: A write whose bits 2:0 differ from the `rxNum` strap is ignored, unless it is the exact idle word. The status word keeps its value, and an active step keeps running.
- R3: Writing the exact idle word 0x9C38 is accepted from any receiver number. It ends any active step and makes the status word 0x9C38.
- R4: A report (type 1) answers with the status word {payload, 2'b00, type, receiver}. The payload depends on the subcode: 0x88 gives {3'b0, capFlags}, 0x89 gives the maximum voltage steps, 0x8A the maximum timing steps, 0x8B the timing offset, 0x8C the voltage offset, 0x8D the voltage sample rate, 0x8E the timing sample rate, and 0x90 the maximum lanes. Each value is zero-extended to 8 bits. Subcodes outside 0x88 to 0x90 are ignored.
- R5: Report subcode 0x8F returns the sample count. The sample count is cleared when a step starts, advances once per cycle while a step is in status 2 or status 0, and saturates at 127.
- R6: A set (type 2) with payload 0x55, 0x0F, or top two payload bits 11 is acknowledged by echoing the written word unchanged. Any other set payload is ignored.
- R7: Set payload 0x55 clears the error count. A set payload with top two bits 11 loads payload bits 5:0 as the new error limit.
- R8: An accepted step shows the status word {status, errCnt, 2'b00, type, receiver}, with the status in bits 15:14 and the error count in bits 13:8. It shows status 1 with an error count of 0 for SETTLE_CYC cycles, and then status 2.
- R9: Each cycle in which `errInj` is high while the step is past setup increments the error count, which saturates at 63. Errors during setup or after a NAK are not counted. While the count exceeds the limit, the status field reads 0.
- R10: A step is refused with status 3 and an error count of 0 in any of these cases: a timing step count (payload bits 5:0) exceeds `maxTimSteps`; a timing step has go-left (payload bit 6) set while capFlags bit 2 (independent left/right) is clear; `capFlags` bit 0 (voltage support) is clear on a voltage step; a voltage step count (payload bits 6:0) exceeds `maxVoltSteps`; a voltage step has go-down (payload bit 7) set while capFlags bit 1 (independent up/down) is clear.
- R11: Any accepted report or set command ends an active step, and the status word then shows that command's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | One-cycle write strobe for the control register |
| cmdData | input | 16 | Command word written |
| rxNum | input | 3 | Receiver number strap |
| capFlags | input | 5 | Capability flags: bit 0 voltage support, bit 1 independent up/down, bit 2 independent left/right, bit 3 sample reporting method, bit 4 independent error sampler |
| maxVoltSteps | input | 7 | Largest voltage step count accepted |
| maxTimSteps | input | 6 | Largest timing step count accepted |
| timOffset | input | 7 | Reported maximum timing offset |
| voltOffset | input | 7 | Reported maximum voltage offset |
| rateV | input | 6 | Reported voltage sample rate |
| rateT | input | 6 | Reported timing sample rate |
| maxLanes | input | 5 | Reported maximum number of lanes margined together |
| errInj | input | 1 | Error-injection input, one error per high cycle |
| statusWord | output | 16 | Lane status register |

## Verification
The assertions take the `rxNum` strap to be static after reset and `cmdWr` to be a single-cycle strobe. The ignore check compares each write's receiver field against a stable strap. The stimulus ties `rxNum` to one value for the whole run, issues every write as a one-cycle pulse, and changes the capability straps only between steps. This means a step is always judged against the straps that were present when it was accepted. The error input is also driven during setup and after a NAK, so that the assertions on uncounted errors are exercised.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  localparam logic [15:0] IDLE_WORD = 16'h9C38;

  localparam logic [2:0] CT_REPORT = 3'd1;
  localparam logic [2:0] CT_SET    = 3'd2;
  localparam logic [2:0] CT_TSTEP  = 3'd3;
  localparam logic [2:0] CT_VSTEP  = 3'd4;

  localparam logic [7:0] RPT_FIRST = 8'h88;
  localparam logic [7:0] RPT_LAST  = 8'h90;
  localparam logic [7:0] SET_CLR   = 8'h55;
  localparam logic [7:0] SET_NORM  = 8'h0F;

  localparam int ERR_W    = 6;
  localparam int SAMPLE_W = 7;

  typedef enum logic [1:0] {
    MS_OVER  = 2'd0,
    MS_SETUP = 2'd1,
    MS_RUN   = 2'd2,
    MS_NAK   = 2'd3
  } mstat_e;

  typedef struct packed {
    logic loadEcho;
    logic loadReport;
    logic clrErr;
    logic setLimit;
    logic startStep;
    logic nakStep;
  } strobe_t;

endpackage

// File: rtl/lmr_ctrl.sv
module lmr_ctrl
  import lmr_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdWr,
  input  logic [15:0]   cmdData,
  input  logic [2:0]    rxNum,
  input  logic          capVolt,
  input  logic          capIndUD,
  input  logic          capIndLR,
  input  logic [6:0]    maxVoltSteps,
  input  logic [5:0]    maxTimSteps,
  output strobe_t       stb,
  output logic          stepMode,
  output mstat_e        stepSts
);

  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [CW-1:0] settleCnt;
  logic [7:0]    pl;
  logic [2:0]    cmdType;
  logic          rxOk;
  logic          tBad;
  logic          vBad;

  assign pl      = cmdData[15:8];
  assign cmdType = cmdData[5:3];
  assign rxOk    = (cmdData[2:0] == rxNum);
  assign tBad    = (pl[5:0] > maxTimSteps) || (pl[6] && !capIndLR);
  assign vBad    = !capVolt || (pl[6:0] > maxVoltSteps) || (pl[7] && !capIndUD);

  always_comb begin
    stb = '0;
    if (cmdWr) begin
      if (cmdData == IDLE_WORD) begin
        stb.loadEcho = 1'b1;
      end else if (rxOk) begin
        case (cmdType)
          CT_REPORT: stb.loadReport = (pl >= RPT_FIRST) && (pl <= RPT_LAST);
          CT_SET: begin
            if (pl == SET_CLR) begin
              stb.clrErr   = 1'b1;
              stb.loadEcho = 1'b1;
            end else if (pl == SET_NORM) begin
              stb.loadEcho = 1'b1;
            end else if (pl[7:6] == 2'b11) begin
              stb.setLimit = 1'b1;
              stb.loadEcho = 1'b1;
            end
          end
          CT_TSTEP: begin
            stb.nakStep   = tBad;
            stb.startStep = !tBad;
          end
          CT_VSTEP: begin
            stb.nakStep   = vBad;
            stb.startStep = !vBad;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepMode  <= 1'b0;
      stepSts   <= MS_SETUP;
      settleCnt <= '0;
    end else if (stb.startStep) begin
      stepMode  <= 1'b1;
      stepSts   <= MS_SETUP;
      settleCnt <= CW'(SETTLE_CYC - 1);
    end else if (stb.nakStep) begin
      stepMode <= 1'b1;
      stepSts  <= MS_NAK;
    end else if (stb.loadEcho || stb.loadReport) begin
      stepMode <= 1'b0;
    end else if (stepMode && stepSts == MS_SETUP) begin
      if (settleCnt == '0) stepSts <= MS_RUN;
      else settleCnt <= settleCnt - 1'b1;
    end
  end

  // R8: setup only ever advances to the running state while no command arrives
  p_settle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stepMode && stepSts == MS_SETUP && !cmdWr) |=>
      (stepMode && (stepSts == MS_SETUP || stepSts == MS_RUN)));

  // R10: a refused step stays refused until a new command is accepted
  p_nak_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stepMode && stepSts == MS_NAK && !cmdWr) |=> (stepMode && stepSts == MS_NAK));

  // R11: an accepted report or set leaves step mode
  p_end_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadEcho || stb.loadReport) |=> !stepMode);

endmodule

// File: rtl/lmr_datapath.sv
module lmr_datapath
  import lmr_pkg::*;
#(
  parameter int DEF_LIMIT = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          stepMode,
  input  mstat_e        stepSts,
  input  logic [15:0]   cmdData,
  input  logic          errInj,
  input  logic [4:0]    capFlags,
  input  logic [6:0]    maxVoltSteps,
  input  logic [5:0]    maxTimSteps,
  input  logic [6:0]    timOffset,
  input  logic [6:0]    voltOffset,
  input  logic [5:0]    rateV,
  input  logic [5:0]    rateT,
  input  logic [4:0]    maxLanes,
  output logic [15:0]   statusWord
);

  localparam logic [ERR_W-1:0]    ERR_MAX    = '1;
  localparam logic [SAMPLE_W-1:0] SAMPLE_MAX = '1;

  logic [15:0]         shownWord;
  logic [5:0]          hdr;
  logic [ERR_W-1:0]    errCnt;
  logic [ERR_W-1:0]    errLimit;
  logic [SAMPLE_W-1:0] sampleCnt;
  logic [7:0]          rptPayload;
  logic                running;
  logic                countEn;
  mstat_e              dispSts;

  always_comb begin
    case (cmdData[15:8])
      8'h88:   rptPayload = {3'b0, capFlags};
      8'h89:   rptPayload = {1'b0, maxVoltSteps};
      8'h8A:   rptPayload = {2'b0, maxTimSteps};
      8'h8B:   rptPayload = {1'b0, timOffset};
      8'h8C:   rptPayload = {1'b0, voltOffset};
      8'h8D:   rptPayload = {2'b0, rateV};
      8'h8E:   rptPayload = {2'b0, rateT};
      8'h8F:   rptPayload = {1'b0, sampleCnt};
      8'h90:   rptPayload = {3'b0, maxLanes};
      default: rptPayload = 8'h00;
    endcase
  end

  assign running = stepMode && (stepSts == MS_RUN);
  assign countEn = running && !stb.loadEcho && !stb.loadReport;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shownWord <= IDLE_WORD;
      hdr       <= '0;
      errCnt    <= '0;
      errLimit  <= ERR_W'(DEF_LIMIT);
      sampleCnt <= '0;
    end else begin
      if (stb.loadEcho)   shownWord <= cmdData;
      if (stb.loadReport) shownWord <= {rptPayload, 2'b00, cmdData[5:0]};
      if (stb.setLimit)   errLimit  <= cmdData[13:8];
      if (stb.startStep) begin
        hdr       <= cmdData[5:0];
        errCnt    <= '0;
        sampleCnt <= '0;
      end else if (stb.nakStep) begin
        hdr    <= cmdData[5:0];
        errCnt <= '0;
      end else if (stb.clrErr) begin
        errCnt <= '0;
      end else if (countEn) begin
        if (errInj && errCnt != ERR_MAX) errCnt <= errCnt + 1'b1;
        if (sampleCnt != SAMPLE_MAX) sampleCnt <= sampleCnt + 1'b1;
      end
    end
  end

  assign dispSts    = (stepSts == MS_RUN && errCnt > errLimit) ? MS_OVER : stepSts;
  assign statusWord = stepMode ? {dispSts, errCnt, 2'b00, hdr} : shownWord;

  // R9: an injected error in a running step advances the count by one
  p_err_inc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && errInj && errCnt != ERR_MAX && stb == '0) |=> (errCnt == $past(errCnt) + 1'b1));

  // R9: the count never wraps past its ceiling
  p_err_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == ERR_MAX && !stb.clrErr && !stb.startStep && !stb.nakStep) |=> (errCnt == ERR_MAX));

  // R9: errors are not counted while the step is still settling
  p_setup_noerr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stepMode && stepSts == MS_SETUP && !stb.startStep && !stb.nakStep && !stb.clrErr)
      |=> $stable(errCnt));

endmodule

// File: rtl/lane_margin_responder.sv
module lane_margin_responder
  import lmr_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int DEF_LIMIT  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [15:0] cmdData,
  input  logic [2:0]  rxNum,
  input  logic [4:0]  capFlags,
  input  logic [6:0]  maxVoltSteps,
  input  logic [5:0]  maxTimSteps,
  input  logic [6:0]  timOffset,
  input  logic [6:0]  voltOffset,
  input  logic [5:0]  rateV,
  input  logic [5:0]  rateT,
  input  logic [4:0]  maxLanes,
  input  logic        errInj,
  output logic [15:0] statusWord
);

  strobe_t stb;
  logic    stepMode;
  mstat_e  stepSts;

  lmr_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdWr        (cmdWr),
    .cmdData      (cmdData),
    .rxNum        (rxNum),
    .capVolt      (capFlags[0]),
    .capIndUD     (capFlags[1]),
    .capIndLR     (capFlags[2]),
    .maxVoltSteps (maxVoltSteps),
    .maxTimSteps  (maxTimSteps),
    .stb          (stb),
    .stepMode     (stepMode),
    .stepSts      (stepSts)
  );

  lmr_datapath #(.DEF_LIMIT(DEF_LIMIT)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .stepMode     (stepMode),
    .stepSts      (stepSts),
    .cmdData      (cmdData),
    .errInj       (errInj),
    .capFlags     (capFlags),
    .maxVoltSteps (maxVoltSteps),
    .maxTimSteps  (maxTimSteps),
    .timOffset    (timOffset),
    .voltOffset   (voltOffset),
    .rateV        (rateV),
    .rateT        (rateT),
    .maxLanes     (maxLanes),
    .statusWord   (statusWord)
  );

  // R2: a write for another receiver leaves an idle status word alone
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData[2:0] != rxNum && cmdData != IDLE_WORD && !stepMode)
      |=> $stable(statusWord));

  // R3: the idle word is always taken and echoed
  p_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdData == IDLE_WORD) |=> (statusWord == IDLE_WORD));

endmodule

// File: tb/tb_lane_margin_responder.sv
module tb_lane_margin_responder;

  localparam int SETTLE = 4;
  localparam int DEFLIM = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdWr;
  logic [15:0] cmdData;
  logic [2:0]  rxNum;
  logic [4:0]  capFlags;
  logic [6:0]  maxVoltSteps;
  logic [5:0]  maxTimSteps;
  logic [6:0]  timOffset;
  logic [6:0]  voltOffset;
  logic [5:0]  rateV;
  logic [5:0]  rateT;
  logic [4:0]  maxLanes;
  logic        errInj;
  logic [15:0] statusWord;

  lane_margin_responder #(.SETTLE_CYC(SETTLE), .DEF_LIMIT(DEFLIM)) dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData), .rxNum(rxNum),
    .capFlags(capFlags), .maxVoltSteps(maxVoltSteps), .maxTimSteps(maxTimSteps),
    .timOffset(timOffset), .voltOffset(voltOffset), .rateV(rateV), .rateT(rateT),
    .maxLanes(maxLanes), .errInj(errInj), .statusWord(statusWord)
  );

  always #10 clk = ~clk;

  int    vecs = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    checking = 0;
  bit    done = 0;
  string curReq = "R1";

  // Behavioural reference state
  int          mMode;
  int          mSts;
  int          mErr;
  int          mLim;
  int          mSettle;
  int          mSample;
  logic [15:0] mWord;
  logic [5:0]  mHdr;

  function automatic logic [15:0] mk(input logic [7:0] p, input int t, input int r);
    return {p, 2'b00, 3'(t), 3'(r)};
  endfunction

  function automatic int rptVal(input int p);
    case (p)
      'h88: return capFlags;
      'h89: return maxVoltSteps;
      'h8A: return maxTimSteps;
      'h8B: return timOffset;
      'h8C: return voltOffset;
      'h8D: return rateV;
      'h8E: return rateT;
      'h8F: return mSample;
      default: return maxLanes;
    endcase
  endfunction

  function automatic logic [15:0] expWord();
    int s;
    if (mMode == 0) return mWord;
    s = (mSts == 2 && mErr > mLim) ? 0 : mSts;
    return {2'(s), 6'(mErr), 2'b00, mHdr};
  endfunction

  always @(posedge clk) begin
    int p, t, r, steps;
    bit acc, bad;
    if (!rstN) begin
      mMode = 0; mSts = 1; mErr = 0; mLim = DEFLIM; mSettle = 0; mSample = 0;
      mWord = 16'h9C38; mHdr = 0;
    end else begin
      acc = 0;
      if (cmdWr) begin
        p = cmdData[15:8]; t = cmdData[5:3]; r = cmdData[2:0];
        if (cmdData == 16'h9C38) begin
          mMode = 0; mWord = cmdData; acc = 1;
        end else if (r == rxNum) begin
          if (t == 1 && p >= 'h88 && p <= 'h90) begin
            mWord = {8'(rptVal(p)), 2'b00, cmdData[5:0]}; mMode = 0; acc = 1;
          end else if (t == 2 && (p == 'h55 || p == 'h0F || p >= 'hC0)) begin
            if (p == 'h55) mErr = 0;
            if (p >= 'hC0) mLim = p % 64;
            mWord = cmdData; mMode = 0; acc = 1;
          end else if (t == 3 || t == 4) begin
            if (t == 3) begin
              steps = p % 64;
              bad = (steps > maxTimSteps) || (((p / 64) % 2 == 1) && !capFlags[2]);
            end else begin
              steps = p % 128;
              bad = !capFlags[0] || (steps > maxVoltSteps) || (p >= 128 && !capFlags[1]);
            end
            mMode = 1; mErr = 0; mHdr = cmdData[5:0]; acc = 1;
            if (bad) mSts = 3;
            else begin mSts = 1; mSettle = SETTLE; mSample = 0; end
          end
        end
      end
      if (!acc && mMode == 1) begin
        if (mSts == 2) begin
          if (mSample < 127) mSample++;
          if (errInj && mErr < 63) mErr++;
        end else if (mSts == 1) begin
          mSettle--;
          if (mSettle == 0) mSts = 2;
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [15:0] e;
    if (checking && !done) begin
      e = expWord();
      vecs++;
      if (statusWord !== e) begin
        fails++;
        $display("FAIL %s cycle %0d: statusWord=%h expected %h", curReq, cycles, statusWord, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected at most 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic expect16(input logic [15:0] got, input logic [15:0] want, input string req);
    vecs++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    cmdWr = 1'b1; cmdData = w;
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  task automatic errs(input int n);
    @(negedge clk);
    errInj = 1'b1;
    repeat (n) @(negedge clk);
    errInj = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; cmdWr = 1'b0; cmdData = 16'h0000; errInj = 1'b0;
    rxNum = 3'd3; capFlags = 5'b10111; maxVoltSteps = 7'd50; maxTimSteps = 6'd20;
    timOffset = 7'd30; voltOffset = 7'd40; rateV = 6'd31; rateT = 6'd33; maxLanes = 5'd7;
    idle(3);
    checking = 1;
    expect16(statusWord, 16'h9C38, "R1 reset word");
    rstN = 1'b1;
    idle(1);

    // R1 default limit of 4, R8 settle, R9 over-limit
    curReq = "R8";
    wr(mk(8'h05, 3, 3));
    expect16(statusWord, 16'h401B, "R8 setup status");
    idle(SETTLE);
    expect16(statusWord, 16'h801B, "R8 running status");
    curReq = "R1";
    errs(4);
    expect16({14'b0, statusWord[15:14]}, 16'd2, "R1 default limit holds at 4 errors");
    curReq = "R9";
    errs(1);
    expect16({14'b0, statusWord[15:14]}, 16'd0, "R9 over limit status");

    // R4 reports
    curReq = "R4";
    wr(mk(8'h88, 1, 3));
    expect16(statusWord, 16'h170B, "R4 caps report");
    for (int s = 'h89; s <= 'h90; s++) begin
      if (s != 'h8F) wr(mk(8'(s), 1, 3));
    end
    expect16(statusWord, 16'h070B, "R4 max lanes report");
    wr(mk(8'h91, 1, 3));
    expect16(statusWord, 16'h070B, "R4 unknown subcode ignored");
    curReq = "R2";
    wr(mk(8'h88, 1, 2));
    expect16(statusWord, 16'h070B, "R2 other receiver ignored");

    // R6 R7 sets
    curReq = "R6";
    wr(mk(8'h55, 2, 3));
    expect16(statusWord, 16'h5513, "R6 clear echo");
    wr(mk(8'h12, 2, 3));
    expect16(statusWord, 16'h5513, "R6 unknown set ignored");
    curReq = "R7";
    wr(mk(8'hC2, 2, 3));
    expect16(statusWord, 16'hC213, "R7 limit echo");

    // R9 errors in setup are not counted, limit 2 applies
    curReq = "R9";
    wr(mk(8'h8A, 4, 3));
    errs(2);
    idle(SETTLE);
    expect16(statusWord[13:8], 6'd0, "R9 setup errors uncounted");
    curReq = "R7";
    errs(2);
    expect16({14'b0, statusWord[15:14]}, 16'd2, "R7 at limit still passing");
    errs(1);
    expect16({14'b0, statusWord[15:14]}, 16'd0, "R7 above limit of 2");
    curReq = "R9";
    errs(70);
    expect16({10'b0, statusWord[13:8]}, 16'd63, "R9 saturate 63");
    idle(130);
    curReq = "R5";
    wr(mk(8'h8F, 1, 3));
    expect16(statusWord, 16'h7F0B, "R5 sample count saturates");

    // R2 ignored during step, R3 idle ends step
    curReq = "R2";
    wr(mk(8'h05, 3, 3));
    idle(SETTLE + 2);
    wr(mk(8'h55, 2, 5));
    expect16({14'b0, statusWord[15:14]}, 16'd2, "R2 step continues");
    curReq = "R5";
    wr(mk(8'h8F, 1, 3));
    curReq = "R3";
    wr(mk(8'h0A, 3, 3));
    idle(2);
    wr(16'h9C38);
    expect16(statusWord, 16'h9C38, "R3 idle ends step");
    curReq = "R11";
    wr(mk(8'h0A, 3, 3));
    idle(SETTLE + 1);
    wr(mk(8'h0F, 2, 3));
    expect16(statusWord, 16'h0F13, "R11 normal settings ends step");

    // R10 refusals
    curReq = "R10";
    wr(mk(8'h15, 3, 3));
    expect16(statusWord, 16'hC01B, "R10 timing steps over max");
    errs(3);
    expect16(statusWord, 16'hC01B, "R10 no counting after NAK");
    wr(mk(8'h33, 4, 3));
    expect16({14'b0, statusWord[15:14]}, 16'd3, "R10 voltage steps over max");
    wr(16'h9C38);
    capFlags = 5'b10010;
    wr(mk(8'h45, 3, 3));
    expect16({14'b0, statusWord[15:14]}, 16'd3, "R10 left without independent timing");
    wr(mk(8'h05, 4, 3));
    expect16({14'b0, statusWord[15:14]}, 16'd3, "R10 voltage unsupported");
    wr(16'h9C38);
    capFlags = 5'b10101;
    wr(mk(8'h85, 4, 3));
    expect16({14'b0, statusWord[15:14]}, 16'd3, "R10 down without independent voltage");
    wr(mk(8'h05, 4, 3));
    expect16({14'b0, statusWord[15:14]}, 16'd1, "R8 voltage up accepted");
    idle(SETTLE + 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule